// File: doc/BRIEF.md
# Lane-Parallel Carry-Less Multiplier

This block performs carry-less (GF(2) polynomial) multiplication on wide vectors split into 128-bit lanes. In every lane one 64-bit quadword of operand A is multiplied by one 64-bit quadword of operand B. Partial products are combined by XOR, so no carries propagate. The full 128-bit product is written back into the same lane position of the result. A single 8-bit selector byte is shared by all lanes. Its bit 0 picks the half of A and its bit 4 picks the half of B.

The lane count is a parameter: 2 lanes gives a 256-bit vector and 4 lanes gives a 512-bit vector. Each lane is a combinational AND/XOR array followed by one register stage. A result appears with `out_valid` one clock after its operands were presented with `in_valid`. There is no back-pressure. Reduction modulo a field polynomial is left to the surrounding logic.

Top module: `lane_clmul`

## Requirements
- R1: Lane k occupies bits [128k+127:128k] of `vec_a`, `vec_b` and `prod`. Each lane's result is the full 128-bit carry-less product of the two selected quadwords. Product bit n is the XOR over all i+j=n of a_i AND b_j.
- R2: `sel[0]` picks the A quadword in every lane: 0 selects lane bits [63:0], 1 selects lane bits [127:64].
- R3: `sel[4]` picks the B quadword in every lane, with the same encoding as R2.
- R4: Selector bits 1, 2, 3, 5, 6 and 7 have no effect on the result.
- R5: All lanes use one selector and read operands only from their own lane. Each lane equals a single-lane product of that lane's inputs, even when every lane carries different data.
- R6: For lane A = {hi 64'h7b5b546573745665, lo 64'h63746f725d53475d} and B = {hi 64'h4869285368617929, lo 64'h5b477565726f6e5d}, the lane result is as follows:
  - selector 8'h00 gives {64'h1d4d84c85c3440c0, 64'h929633d5d36f0451};
  - selector 8'h10 gives {64'h1bd17c8d556ab5a1, 64'h7fa540ac2a281315};
  - selector 8'h01 gives {64'h1a2bf6db3a30862f, 64'hbabf262df4b7d5c9};
  - selector 8'h11 gives {64'h1d1e1f2c592e7c45, 64'hd66ee03e410fd4ed}.
- R7: If both selected quadwords are 64'h8000000000000000, the lane result has only bit 126 set.
- R8: Bit 127 of every lane of a valid result is zero.
- R9: `out_valid` is `in_valid` delayed by exactly one clock. When `out_valid` is high, `prod` holds the product of the operands accepted on the previous edge.
- R10: When `in_valid` is low at an edge, `prod` keeps its value.
- R11: When `rst_n` is low at a clock edge, `out_valid` and `prod` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and selector are valid this cycle |
| vec_a | input | LANES*128 | Operand A, one 128-bit lane per slot |
| vec_b | input | LANES*128 | Operand B, one 128-bit lane per slot |
| sel | input | 8 | Shared quadword selector (bit 0 for A, bit 4 for B) |
| out_valid | output | 1 | Result register holds a new product |
| prod | output | LANES*128 | Per-lane 128-bit carry-less products |

## Verification
The bench targets half selection and lane isolation.
- It uses all four selector combinations and also selectors whose ignored bits are set. A design that decoded the wrong bit or reversed a half would then return the product of the wrong quadwords.
- Random operands differ from lane to lane. A lane that read a neighbour's data, or a fixed lane index, would show up against the bit-serial shift-and-XOR reference.
- The single-top-bit operands reach the edge of the partial-product array. An off-by-one in the bit indexing would move the result away from bit 126.
- Idle cycles and a mid-run reset expose a register that loads on every edge or does not clear.

// File: rtl/lane_clmul_pkg.sv
// Shared widths for the lane-parallel carry-less multiplier.
package lane_clmul_pkg;
    localparam int QW_W   = 64;          // quadword width
    localparam int LANE_W = 2 * QW_W;    // lane / product width
    localparam int SEL_W  = 8;           // selector byte width
    localparam int SEL_A_BIT = 0;        // selector bit choosing A half
    localparam int SEL_B_BIT = 4;        // selector bit choosing B half

    typedef logic [QW_W-1:0]   qword_t;
    typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/clmul_array.sv
// Combinational carry-less multiplier for two QW_W-bit polynomials.
// Assumes: purely combinational, no reduction; the product is 2*QW_W bits
// wide and its top bit can never be set.
module clmul_array
    import lane_clmul_pkg::*;
(
    input  qword_t mul_x,
    input  qword_t mul_y,
    output lane_t  mul_p
);
    // AND/XOR array: each product bit XORs every partial term on its diagonal
    always_comb begin
        mul_p = '0;
        for (int n = 0; n < LANE_W; n++) begin
            for (int i = 0; i < QW_W; i++) begin
                if ((n >= i) && ((n - i) < QW_W)) begin
                    mul_p[n] = mul_p[n] ^ (mul_x[i] & mul_y[n-i]);
                end
            end
        end
    end
endmodule

// File: rtl/clmul_lane.sv
// One 128-bit lane: picks a quadword from each operand and multiplies them.
// Assumes: the selector is shared with other lanes; only its A and B
// selection bits are decoded here, all other bits are unused.
module clmul_lane
    import lane_clmul_pkg::*;
(
    input  lane_t              ln_a,
    input  lane_t              ln_b,
    input  logic [SEL_W-1:0]   ln_sel,
    output lane_t              ln_p
);
    qword_t pick_a;
    qword_t pick_b;

    // Half select: 0 = low quadword, 1 = high quadword
    always_comb begin
        pick_a = ln_sel[SEL_A_BIT] ? ln_a[LANE_W-1:QW_W] : ln_a[QW_W-1:0];
        pick_b = ln_sel[SEL_B_BIT] ? ln_b[LANE_W-1:QW_W] : ln_b[QW_W-1:0];
    end

    clmul_array u_array (
        .mul_x (pick_a),
        .mul_y (pick_b),
        .mul_p (ln_p)
    );
endmodule

// File: rtl/lane_clmul.sv
// Lane-parallel carry-less multiplier with one output register stage.
// Assumes: LANES is 2 or 4; no back-pressure; synchronous active-low reset.
// Each lane reads only its own slot of vec_a/vec_b; all share sel.
module lane_clmul
    import lane_clmul_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*128-1:0]    vec_a,
    input  logic [LANES*128-1:0]    vec_b,
    input  logic [7:0]              sel,
    output logic                    out_valid,
    output logic [LANES*128-1:0]    prod
);
    localparam int VEC_W = LANES * LANE_W;

    logic [VEC_W-1:0] prod_d;

    // One multiplier lane per 128-bit slot
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        clmul_lane u_lane (
            .ln_a   (vec_a[g*LANE_W +: LANE_W]),
            .ln_b   (vec_b[g*LANE_W +: LANE_W]),
            .ln_sel (sel),
            .ln_p   (prod_d[g*LANE_W +: LANE_W])
        );
    end

    // Output stage: register products on accepted input, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            prod      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                prod <= prod_d;
            end
        end
    end
endmodule

// File: rtl/lane_clmul_chk.sv
// Property checker for lane_clmul, attached with bind below.
// Assumes: it only observes the top-level ports.
module lane_clmul_chk #(
    parameter int LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [LANES*128-1:0] prod,
    input logic                 out_valid
);
    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(prod));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (prod == '0)));

    for (genvar g = 0; g < LANES; g++) begin : g_top
        // R8
        top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> !prod[g*128 + 127]);
    end
endmodule

bind lane_clmul lane_clmul_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .prod      (prod),
    .out_valid (out_valid)
);

// File: tb/lane_clmul_bench.sv
module lane_clmul_bench;
    localparam int LANES = 4;
    localparam int VW    = LANES * 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] vec_a = '0;
    logic [VW-1:0] vec_b = '0;
    logic [7:0]    sel = '0;
    logic          out_valid;
    logic [VW-1:0] prod;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lane_clmul #(.LANES(LANES)) u_lane_clmul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .vec_a(vec_a), .vec_b(vec_b), .sel(sel),
        .out_valid(out_valid), .prod(prod)
    );

    // Bit-serial shift-and-XOR reference
    function automatic logic [127:0] ref_mul(input logic [63:0] x, input logic [63:0] y);
        logic [127:0] acc = '0;
        logic [127:0] sh  = {64'd0, x};
        for (int i = 0; i < 64; i++) begin
            if (y[i]) acc = acc ^ sh;
            sh = sh << 1;
        end
        return acc;
    endfunction

    function automatic logic [VW-1:0] ref_vec(input logic [VW-1:0] a,
                                              input logic [VW-1:0] b,
                                              input logic [7:0] s);
        logic [VW-1:0] r;
        for (int k = 0; k < LANES; k++) begin
            logic [127:0] la = a[k*128 +: 128];
            logic [127:0] lb = b[k*128 +: 128];
            r[k*128 +: 128] = ref_mul(s[0] ? la[127:64] : la[63:0],
                                      s[4] ? lb[127:64] : lb[63:0]);
        end
        return r;
    endfunction

    task automatic check_bit(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive at negedge, result sampled at the following negedge
    task automatic apply(input logic v, input logic [VW-1:0] a,
                         input logic [VW-1:0] b, input logic [7:0] s);
        @(negedge clk);
        in_valid = v; vec_a = a; vec_b = b; sel = s;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [VW-1:0] bcast(input logic [127:0] l);
        logic [VW-1:0] r;
        for (int k = 0; k < LANES; k++) r[k*128 +: 128] = l;
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] r;
        for (int k = 0; k < VW/32; k++) r[k*32 +: 32] = $urandom;
        return r;
    endfunction

    initial begin
        logic [127:0] ka = {64'h7b5b546573745665, 64'h63746f725d53475d};
        logic [127:0] kb = {64'h4869285368617929, 64'h5b477565726f6e5d};
        logic [VW-1:0] ra, rb, held;
        logic [7:0] s;
        void'($urandom(32'd2024));

        // R11: reset state
        repeat (3) @(negedge clk);
        check_bit("R11 out_valid in reset", out_valid, 1'b0);
        check_vec("R11 prod in reset", prod, '0);
        rst_n = 1'b1;

        // R6 known answers, all four half choices (R2, R3)
        apply(1'b1, bcast(ka), bcast(kb), 8'h00);
        check_bit("R9 out_valid after input", out_valid, 1'b1);
        check_vec("R6 sel 00", prod, bcast({64'h1d4d84c85c3440c0, 64'h929633d5d36f0451}));
        apply(1'b1, bcast(ka), bcast(kb), 8'h10);
        check_vec("R6 R3 sel 10", prod, bcast({64'h1bd17c8d556ab5a1, 64'h7fa540ac2a281315}));
        apply(1'b1, bcast(ka), bcast(kb), 8'h01);
        check_vec("R6 R2 sel 01", prod, bcast({64'h1a2bf6db3a30862f, 64'hbabf262df4b7d5c9}));
        apply(1'b1, bcast(ka), bcast(kb), 8'h11);
        check_vec("R6 sel 11", prod, bcast({64'h1d1e1f2c592e7c45, 64'hd66ee03e410fd4ed}));

        // R4: ignored selector bits set
        apply(1'b1, bcast(ka), bcast(kb), 8'hEE);
        check_vec("R4 sel EE", prod, bcast({64'h1d4d84c85c3440c0, 64'h929633d5d36f0451}));
        apply(1'b1, bcast(ka), bcast(kb), 8'hFF);
        check_vec("R4 sel FF", prod, bcast({64'h1d1e1f2c592e7c45, 64'hd66ee03e410fd4ed}));

        // R7: top bits only
        apply(1'b1, bcast({64'd0, 64'h8000000000000000}), bcast({64'd0, 64'h8000000000000000}), 8'h00);
        check_vec("R7 top bit square", prod, bcast({64'h4000000000000000, 64'd0}));
        for (int k = 0; k < LANES; k++) check_bit("R8 bit127", prod[k*128 + 127], 1'b0);

        // R1 R5: random per-lane data, all selector patterns
        for (int t = 0; t < 64; t++) begin
            ra = rnd_vec(); rb = rnd_vec();
            s = (t < 4) ? {3'b000, t[1], 3'b000, t[0]} : 8'($urandom);
            apply(1'b1, ra, rb, s);
            check_vec($sformatf("R1 R5 random sel %h", s), prod, ref_vec(ra, rb, s));
        end

        // R10: idle inputs leave the result alone
        held = prod;
        apply(1'b0, rnd_vec(), rnd_vec(), 8'h11);
        check_bit("R9 out_valid idle", out_valid, 1'b0);
        check_vec("R10 prod held", prod, held);

        // R11: reset mid-run clears state
        apply(1'b1, rnd_vec(), rnd_vec(), 8'h01);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check_bit("R11 out_valid cleared", out_valid, 1'b0);
        check_vec("R11 prod cleared", prod, '0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule